// File: doc/BRIEF.md
# Blocked Load Replay Scheduler

This block is a small replay queue beside the load pipeline of an out-of-order core with guarded speculative memory access. A load that was stopped before address translation because it was flagged suspicious, a load whose translation was refused because it was still speculative and its page had no approval yet, and a load parked behind a pending permission-reset command are all written into the queue. Each entry holds the load's tracker index and a code for why it was stopped. The entry waits until the condition that matches that code is lifted.

Each cycle the core drives per-index pulses into the block: "now safe", meaning the load is bound to commit, and "no longer suspicious". It also drives a single pulse when the pending reset command has executed, the current oldest tracker index (the head), and a flush request. An entry whose wake condition has been met becomes eligible. A suspicious-only load may therefore re-run speculatively before it is safe. Every cycle the oldest eligible entry, measured from the head, is offered on the issue port and leaves the queue.

Top module: `replay_sched`

## Requirements
- R1: After reset the queue is empty: iss_valid is 0 and ins_stall is 0 while ins_valid is 0.
- R2: ins_reason code 0 means held back as suspicious, code 1 means refused translation while unsafe, code 2 means waiting behind a pending reset command, and code 3 is handled exactly like code 1. An accepted insert creates an entry that is not eligible unless a matching wake arrives in the same cycle.
- R3: A safe_pulse bit at an entry's tracker index makes that entry eligible, whatever its reason code.
- R4: An unsusp_pulse bit at an entry's index makes a code-0 entry eligible and has no effect on entries of codes 1, 2 or 3.
- R5: reset_cmd_done makes every code-2 entry eligible and has no effect on entries of codes 0, 1 or 3.
- R6: A wake pulse for the inserted index in the insert cycle makes the new entry eligible, so it is offered in the next cycle.
- R7: iss_valid/iss_idx present, combinationally from the stored entries, the eligible entry with the smallest age ((index − head_idx) mod 16). At most one entry is offered per cycle, and it is removed at that clock edge.
- R8: When flush_valid is high, every entry whose age is at least the age of flush_idx is removed at the edge, none of these is offered in that cycle, and an insert whose index falls in that range is dropped.
- R9: With all 8 entries occupied, ins_stall equals ins_valid and the insert is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| head_idx | input | 4 | Tracker index of the oldest in-flight instruction |
| ins_valid | input | 1 | Insert request |
| ins_idx | input | 4 | Tracker index of the load being inserted |
| ins_reason | input | 2 | Blocking reason code (see R2) |
| ins_stall | output | 1 | Insert refused because the queue is full |
| safe_pulse | input | 16 | One bit per tracker index: load became safe |
| unsusp_pulse | input | 16 | One bit per tracker index: suspicious flag cleared |
| reset_cmd_done | input | 1 | Pending reset command has executed |
| flush_valid | input | 1 | Flush request |
| flush_idx | input | 4 | Oldest tracker index removed by the flush |
| iss_valid | output | 1 | A load is reissued this cycle |
| iss_idx | output | 4 | Tracker index of the reissued load |

## Verification
The hardest situation to reach is age ordering after the tracker index has wrapped. Two entries must be eligible together while the head sits above one of them numerically, so that the lower index is the younger load. The bench gets there by moving head_idx to 12, parking loads at indices 13 and 1, and waking both with one safe pulse. A full queue that holds eight unwoken entries when a ninth insert arrives is the second hard case. It is reached by filling the queue with suspicious loads and sending no wake pulses until the stall has been observed.

// File: rtl/replay_pkg.sv
package replay_pkg;

    localparam int RQ_DEPTH = 8;
    localparam int RQ_IDXW  = 4;

    typedef enum logic [1:0] {
        RSN_SUSP    = 2'd0,
        RSN_UNSAFE  = 2'd1,
        RSN_RSTWAIT = 2'd2,
        RSN_RSVD    = 2'd3
    } rsn_e;

    // Reserved code is folded onto the translation-refusal kind (R2)
    function automatic rsn_e rsn_norm(input logic [1:0] code);
        rsn_e r;
        r = rsn_e'(code);
        if (r == RSN_RSVD) r = RSN_UNSAFE;
        return r;
    endfunction

endpackage

// File: rtl/rq_wake_eval.sv
module rq_wake_eval
    import replay_pkg::*;
#(
    parameter int IDXW = RQ_IDXW,
    localparam int NIDX = 1 << IDXW
) (
    input  rsn_e            rsn,
    input  logic [IDXW-1:0] idx,
    input  logic [NIDX-1:0] safe_vec,
    input  logic [NIDX-1:0] unsusp_vec,
    input  logic            rst_done,
    output logic            wake
);
    logic safe_hit;
    logic unsusp_hit;

    always_comb begin
        safe_hit   = safe_vec[idx];
        unsusp_hit = unsusp_vec[idx];
        wake       = safe_hit;
        unique case (rsn)
            RSN_SUSP:    wake = safe_hit | unsusp_hit;
            RSN_RSTWAIT: wake = safe_hit | rst_done;
            default:     wake = safe_hit;
        endcase
    end

endmodule

// File: rtl/rq_oldest_pick.sv
module rq_oldest_pick #(
    parameter int DEPTH = 8,
    parameter int IDXW  = 4,
    localparam int SW   = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]      cand,
    input  logic [DEPTH*IDXW-1:0] idx_flat,
    input  logic [IDXW-1:0]       head,
    output logic                  found,
    output logic [SW-1:0]         slot
);
    logic [IDXW-1:0] best_age;
    logic [IDXW-1:0] age;

    always_comb begin
        found    = 1'b0;
        slot     = '0;
        best_age = '1;
        age      = '0;
        for (int i = 0; i < DEPTH; i++) begin
            age = idx_flat[i*IDXW +: IDXW] - head;
            if (cand[i] && (!found || age < best_age)) begin
                found    = 1'b1;
                slot     = SW'(i);
                best_age = age;
            end
        end
    end

endmodule

// File: rtl/rq_free_find.sv
module rq_free_find #(
    parameter int DEPTH = 8,
    localparam int SW   = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] used,
    output logic             has_free,
    output logic [SW-1:0]    slot
);
    always_comb begin
        has_free = 1'b0;
        slot     = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!used[i]) begin
                has_free = 1'b1;
                slot     = SW'(i);
            end
        end
    end

endmodule

// File: rtl/replay_sched.sv
module replay_sched
    import replay_pkg::*;
#(
    parameter int DEPTH = RQ_DEPTH,
    parameter int IDXW  = RQ_IDXW,
    localparam int SW   = $clog2(DEPTH),
    localparam int NIDX = 1 << IDXW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IDXW-1:0] head_idx,
    input  logic            ins_valid,
    input  logic [IDXW-1:0] ins_idx,
    input  logic [1:0]      ins_reason,
    output logic            ins_stall,
    input  logic [NIDX-1:0] safe_pulse,
    input  logic [NIDX-1:0] unsusp_pulse,
    input  logic            reset_cmd_done,
    input  logic            flush_valid,
    input  logic [IDXW-1:0] flush_idx,
    output logic            iss_valid,
    output logic [IDXW-1:0] iss_idx
);
    typedef struct packed {
        logic            vld;
        logic            elg;
        logic [IDXW-1:0] idx;
        rsn_e            rsn;
    } ent_t;

    typedef struct packed {
        ent_t [DEPTH-1:0] ent;
    } st_t;

    st_t st_q, st_d;

    logic [DEPTH-1:0]      used_vec;
    logic [DEPTH*IDXW-1:0] idx_flat;
    logic [DEPTH-1:0]      wake_vec;
    logic [DEPTH-1:0]      flush_hit;
    logic [DEPTH-1:0]      cand_vec;
    logic [IDXW-1:0]       flush_age;
    logic [IDXW-1:0]       ins_age;
    rsn_e                  ins_rsn;
    logic                  ins_wake;
    logic                  ins_flushed;
    logic                  has_free;
    logic [SW-1:0]         free_slot;
    logic                  pick_found;
    logic [SW-1:0]         pick_slot;

    // Flattened views of the stored entries
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            used_vec[i]                = st_q.ent[i].vld;
            idx_flat[i*IDXW +: IDXW]   = st_q.ent[i].idx;
        end
    end

    // Per-entry wake evaluation; one extra copy serves the insert port
    for (genvar g = 0; g < DEPTH; g++) begin : g_wake
        rq_wake_eval #(.IDXW(IDXW)) u_wake (
            .rsn        (st_q.ent[g].rsn),
            .idx        (st_q.ent[g].idx),
            .safe_vec   (safe_pulse),
            .unsusp_vec (unsusp_pulse),
            .rst_done   (reset_cmd_done),
            .wake       (wake_vec[g])
        );
    end

    assign ins_rsn = rsn_norm(ins_reason);

    rq_wake_eval #(.IDXW(IDXW)) u_ins_wake (
        .rsn        (ins_rsn),
        .idx        (ins_idx),
        .safe_vec   (safe_pulse),
        .unsusp_vec (unsusp_pulse),
        .rst_done   (reset_cmd_done),
        .wake       (ins_wake)
    );

    // Flush range and issue candidates
    always_comb begin
        flush_age   = flush_idx - head_idx;
        ins_age     = ins_idx - head_idx;
        ins_flushed = flush_valid && (ins_age >= flush_age);
        for (int i = 0; i < DEPTH; i++) begin
            flush_hit[i] = flush_valid && st_q.ent[i].vld &&
                           ((st_q.ent[i].idx - head_idx) >= flush_age);
            cand_vec[i]  = st_q.ent[i].vld && st_q.ent[i].elg && !flush_hit[i];
        end
    end

    rq_oldest_pick #(.DEPTH(DEPTH), .IDXW(IDXW)) u_pick (
        .cand     (cand_vec),
        .idx_flat (idx_flat),
        .head     (head_idx),
        .found    (pick_found),
        .slot     (pick_slot)
    );

    rq_free_find #(.DEPTH(DEPTH)) u_free (
        .used     (used_vec),
        .has_free (has_free),
        .slot     (free_slot)
    );

    assign iss_valid = pick_found;
    assign iss_idx   = st_q.ent[pick_slot].idx;
    assign ins_stall = ins_valid && !has_free;

    // Next-state computation
    always_comb begin
        st_d = st_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (flush_hit[i] || (pick_found && (pick_slot == SW'(i)))) begin
                st_d.ent[i].vld = 1'b0;
                st_d.ent[i].elg = 1'b0;
            end else if (st_q.ent[i].vld && wake_vec[i]) begin
                st_d.ent[i].elg = 1'b1;
            end
        end
        if (ins_valid && has_free && !ins_flushed) begin
            st_d.ent[free_slot].vld = 1'b1;
            st_d.ent[free_slot].elg = ins_wake;
            st_d.ent[free_slot].idx = ins_idx;
            st_d.ent[free_slot].rsn = ins_rsn;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/replay_sched_chk.sv
module replay_sched_chk #(
    parameter int DEPTH = 8,
    parameter int IDXW  = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  ins_valid,
    input logic                  ins_stall,
    input logic                  iss_valid,
    input logic                  flush_valid,
    input logic [IDXW-1:0]       flush_idx,
    input logic [IDXW-1:0]       head_idx,
    input logic [DEPTH-1:0]      used_vec,
    input logic [DEPTH*IDXW-1:0] idx_flat
);
    logic            pf_v;
    logic [IDXW-1:0] pf_age_lim;
    logic [IDXW-1:0] pf_head;
    logic            survivor_bad;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf_v       <= 1'b0;
            pf_age_lim <= '0;
            pf_head    <= '0;
        end else begin
            pf_v       <= flush_valid;
            pf_age_lim <= flush_idx - head_idx;
            pf_head    <= head_idx;
        end
    end

    always_comb begin
        survivor_bad = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (used_vec[i] && ((idx_flat[i*IDXW +: IDXW] - pf_head) >= pf_age_lim))
                survivor_bad = 1'b1;
        end
    end

    assert_empty_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (used_vec == '0 && !iss_valid));

    assert_stall_only_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ins_stall |-> (&used_vec));

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_stall && !flush_valid) |=> ($countones(used_vec) <= $past($countones(used_vec))));

    assert_issue_frees_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !ins_valid && !flush_valid) |=>
            ($countones(used_vec) == $past($countones(used_vec)) - 1));

    assert_flush_clears_young_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pf_v |-> !survivor_bad);

endmodule

bind replay_sched replay_sched_chk #(.DEPTH(DEPTH), .IDXW(IDXW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ins_valid   (ins_valid),
    .ins_stall   (ins_stall),
    .iss_valid   (iss_valid),
    .flush_valid (flush_valid),
    .flush_idx   (flush_idx),
    .head_idx    (head_idx),
    .used_vec    (used_vec),
    .idx_flat    (idx_flat)
);

// File: tb/sim_replay_sched.sv
module sim_replay_sched;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  head_idx;
    logic        ins_valid;
    logic [3:0]  ins_idx;
    logic [1:0]  ins_reason;
    logic        ins_stall;
    logic [15:0] safe_pulse;
    logic [15:0] unsusp_pulse;
    logic        reset_cmd_done;
    logic        flush_valid;
    logic [3:0]  flush_idx;
    logic        iss_valid;
    logic [3:0]  iss_idx;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    replay_sched u0 (
        .clk(clk), .rst_n(rst_n), .head_idx(head_idx),
        .ins_valid(ins_valid), .ins_idx(ins_idx), .ins_reason(ins_reason),
        .ins_stall(ins_stall), .safe_pulse(safe_pulse), .unsusp_pulse(unsusp_pulse),
        .reset_cmd_done(reset_cmd_done), .flush_valid(flush_valid), .flush_idx(flush_idx),
        .iss_valid(iss_valid), .iss_idx(iss_idx)
    );

    typedef struct packed {
        logic        iv;
        logic [3:0]  ii;
        logic [1:0]  ir;
        logic [15:0] sf;
        logic [15:0] us;
        logic        rd;
        logic        ev;
        logic [3:0]  ei;
    } vec_t;

    // head stays 0 for the table; expectations are iss after the step's edge
    localparam int NV = 13;
    localparam vec_t VT [NV] = '{
        '{1'b1, 4'd3, 2'd0, 16'h0000, 16'h0000, 1'b0, 1'b0, 4'd0}, // R2 susp parked
        '{1'b1, 4'd5, 2'd1, 16'h0000, 16'h0000, 1'b0, 1'b0, 4'd0}, // R2 unsafe parked
        '{1'b0, 4'd0, 2'd0, 16'h0000, 16'h0020, 1'b0, 1'b0, 4'd0}, // R4 unsusp ignored for unsafe
        '{1'b0, 4'd0, 2'd0, 16'h0000, 16'h0008, 1'b0, 1'b1, 4'd3}, // R4 susp woken
        '{1'b0, 4'd0, 2'd0, 16'h0000, 16'h0000, 1'b0, 1'b0, 4'd0}, // R7 removed after issue
        '{1'b1, 4'd7, 2'd2, 16'h0000, 16'h0000, 1'b0, 1'b0, 4'd0}, // R2 reset-wait parked
        '{1'b0, 4'd0, 2'd0, 16'h0020, 16'h0000, 1'b1, 1'b1, 4'd5}, // R3 R5 R7 both wake, 5 older
        '{1'b0, 4'd0, 2'd0, 16'h0000, 16'h0000, 1'b0, 1'b1, 4'd7}, // R7 next one
        '{1'b0, 4'd0, 2'd0, 16'h0000, 16'h0000, 1'b0, 1'b0, 4'd0}, // R7 drained
        '{1'b1, 4'd9, 2'd1, 16'h0200, 16'h0000, 1'b0, 1'b1, 4'd9}, // R6 safe with insert
        '{1'b0, 4'd0, 2'd0, 16'h0000, 16'h0000, 1'b0, 1'b0, 4'd0},
        '{1'b1, 4'd2, 2'd0, 16'h0000, 16'h0004, 1'b0, 1'b1, 4'd2}, // R6 unsusp with insert
        '{1'b0, 4'd0, 2'd0, 16'h0000, 16'h0000, 1'b0, 1'b0, 4'd0}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle();
        ins_valid      = 1'b0;
        ins_idx        = '0;
        ins_reason     = '0;
        safe_pulse     = '0;
        unsusp_pulse   = '0;
        reset_cmd_done = 1'b0;
        flush_valid    = 1'b0;
        flush_idx      = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        idle();
        #1;
    endtask

    task automatic ins(input logic [3:0] i, input logic [1:0] r);
        ins_valid = 1'b1; ins_idx = i; ins_reason = r;
        tick();
    endtask

    // expect the issue port: v = valid, i = index
    task automatic expect_iss(input string req, input bit v, input logic [3:0] i);
        check(iss_valid == v, req, int'(iss_valid), int'(v));
        if (v) check(iss_idx == i, req, int'(iss_idx), int'(i));
    endtask

    function automatic string pick_req(input int k);
        case (k)
            0, 1, 5: return "R2";
            2, 3:    return "R4";
            6:       return "R3/R5";
            9, 11:   return "R6";
            default: return "R7";
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        idle();
        head_idx = '0;
        rst_n    = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R1 reset state
        check(!iss_valid, "R1", int'(iss_valid), 0);
        check(!ins_stall, "R1", int'(ins_stall), 0);

        // vector table
        for (int k = 0; k < NV; k++) begin
            ins_valid      = VT[k].iv;
            ins_idx        = VT[k].ii;
            ins_reason     = VT[k].ir;
            safe_pulse     = VT[k].sf;
            unsusp_pulse   = VT[k].us;
            reset_cmd_done = VT[k].rd;
            tick();
            expect_iss(pick_req(k), VT[k].ev, VT[k].ei);
        end

        // R2 code 3 acts like code 1; R4 unsusp ignored for it
        ins(4'd11, 2'd3);
        unsusp_pulse = 16'h0800; tick();
        expect_iss("R2", 1'b0, 4'd0);
        safe_pulse = 16'h0800; tick();
        expect_iss("R3", 1'b1, 4'd11);
        tick();

        // R4: unsusp does not wake reset-wait; R3 safe does
        ins(4'd6, 2'd2);
        unsusp_pulse = 16'h0040; tick();
        expect_iss("R4", 1'b0, 4'd0);
        safe_pulse = 16'h0040; tick();
        expect_iss("R3", 1'b1, 4'd6);
        tick();

        // R5: reset done ignored by suspicious entry
        ins(4'd4, 2'd0);
        reset_cmd_done = 1'b1; tick();
        expect_iss("R5", 1'b0, 4'd0);
        unsusp_pulse = 16'h0010; tick();
        expect_iss("R4", 1'b1, 4'd4);
        tick();

        // R7 wrap-around age: head 12, index 13 older than 1
        head_idx = 4'd12;
        ins(4'd1, 2'd1);
        ins(4'd13, 2'd1);
        safe_pulse = 16'h2002; tick();
        expect_iss("R7", 1'b1, 4'd13);
        tick();
        expect_iss("R7", 1'b1, 4'd1);
        tick();
        expect_iss("R7", 1'b0, 4'd0);
        head_idx = 4'd0;

        // R9 full queue
        for (int k = 0; k < 8; k++) ins(4'(k), 2'd0);
        ins_valid = 1'b1; ins_idx = 4'd8; ins_reason = 2'd1;
        #1;
        check(ins_stall, "R9", int'(ins_stall), 1);
        tick();
        check(!ins_stall, "R9", int'(ins_stall), 0);
        safe_pulse = 16'hFFFF; tick();
        for (int k = 0; k < 8; k++) begin
            expect_iss("R9", 1'b1, 4'(k));
            tick();
        end
        expect_iss("R9", 1'b0, 4'd0);

        // R8 flush removes 4 and 6, keeps 1
        ins(4'd1, 2'd0);
        ins(4'd4, 2'd0);
        ins(4'd6, 2'd0);
        flush_valid = 1'b1; flush_idx = 4'd4; tick();
        safe_pulse = 16'hFFFF; tick();
        expect_iss("R8", 1'b1, 4'd1);
        tick();
        expect_iss("R8", 1'b0, 4'd0);

        // R8 eligible entry hidden by same-cycle flush
        ins(4'd10, 2'd1);
        safe_pulse = 16'h0400; tick();
        expect_iss("R8", 1'b1, 4'd10);
        flush_valid = 1'b1; flush_idx = 4'd10;
        #1;
        expect_iss("R8", 1'b0, 4'd0);
        tick();
        expect_iss("R8", 1'b0, 4'd0);

        // R8 insert inside flush range dropped
        ins_valid = 1'b1; ins_idx = 4'd5; ins_reason = 2'd0;
        flush_valid = 1'b1; flush_idx = 4'd3; tick();
        safe_pulse = 16'hFFFF; tick();
        expect_iss("R8", 1'b0, 4'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule